// File: doc/BRIEF.md
# Multi-Channel Interval Timer Array

A register-mapped timer peripheral with six independent down-counters. Software programs each channel with a reload interval and a control byte, then enables it. Every cycle in which the shared prescaled tick input is high, each running channel counts down by one. When a channel reaches the end of its interval, it expires. A periodic channel then reloads and keeps running. A one-shot channel stops and clears its own enable bit.

Each expiry sets that channel's bit in a shared sticky status register. Software clears status bits by writing ones to them. A channel also drives a one-cycle pulse on its own interrupt line, but only if its bit in the shared interrupt-enable register is set. Two watchdog words are kept as plain read/write storage and have no function.

The register port is a plain strobe bus. A write takes effect on the clock edge where the write strobe is high. A read returns data on the edge after the read strobe.

Top module: `ivt_array`

## Requirements
- R1: After reset, interrupt-enable, interrupt-status, every interval and every count read 0. Every control register reads 0x04 (clock-select field [3:2] = 01), every channel is stopped, and irq_o is all zero.
- R2: The register map uses byte offsets:
  - 0x00 is interrupt enable and 0x04 is interrupt status.
  - Channel i (0..5) owns the group at 0x10*(i+1). Within a group, control is at +0x0, interval at +0x4 and count at +0x8.
  - 0x90 and 0x94 are two 32-bit watchdog storage words.
  - Every other offset reads 0 and ignores writes.
- R3: A write to interrupt status clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to a channel's interval stores the new limit and loads the count with that same value.
- R5: Control bits:
  - Bit 0 is enable, bits [3:2] are clock select, and bit 7 is one-shot mode.
  - Writing 1 to bit 1 copies the current interval into the count. Bit 1 always reads back as 0.
  - Writes to the count register are ignored.
- R6: A channel with enable set decrements its count by one on each cycle with tick_i high. A channel with enable clear holds its count.
- R7: A periodic channel (bit 7 = 0) expires on a tick that finds its count at 1 or 0. Its count then becomes the interval and it keeps running, so it expires once every `interval` ticks.
- R8: A one-shot channel (bit 7 = 1) expires in the same way, then its count is 0, its enable bit reads 0 and further ticks leave it unchanged.
- R9: An expiry of channel i sets status bit i on the clock edge of the expiring tick, whether or not its interrupt is enabled.
- R10: irq_o[i] is high for exactly one cycle after the edge of an expiring tick of channel i, and only when interrupt-enable bit i is set.
- R11: Two cases decide conflicts in the same cycle:
  - A register write to a channel in the same cycle as a tick takes effect instead of that tick.
  - A status bit set by an expiry wins over a write-one-to-clear of that bit.
- R12: rdata_o is loaded only on edges where rd_en_i is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled count enable shared by all channels |
| addr_i | input | ADDR_W (10) | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_CH (6) | Per-channel interrupt pulses |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions. The stimulus makes them happen on purpose:
- The bench holds tick_i high in the very cycle it writes a channel's interval, then checks that the count equals the written value and not that value minus one.
- It programs a channel with interval 1 so that it expires on every tick, then writes a clear to that channel's status bit in an expiring cycle. It then checks that the bit survives.

Exact pulse timing on irq_o is checked by counting ticks from a known count to the expiring edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // byte offsets of the shared words
  localparam logic [7:0] OFF_IEN  = 8'h00;
  localparam logic [7:0] OFF_IST  = 8'h04;
  localparam logic [7:0] OFF_WDC  = 8'h90;
  localparam logic [7:0] OFF_WDM  = 8'h94;
  // offsets inside a channel group
  localparam logic [3:0] SUB_CTRL = 4'h0;
  localparam logic [3:0] SUB_IVAL = 4'h4;
  localparam logic [3:0] SUB_CNT  = 4'h8;
  // control field positions
  localparam int CB_EN     = 0;
  localparam int CB_RELOAD = 1;
  localparam int CB_ONCE   = 7;
  localparam logic [7:0] CTRL_RST = 8'h04;
endpackage

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ctrl_we_i,
  input  logic             ival_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [7:0]       ctrl_o,
  output logic [CNT_W-1:0] ival_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [7:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] ival_q, ival_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             expire;

  always_comb begin
    ctrl_d = ctrl_q;
    ival_d = ival_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (ctrl_we_i) begin
      ctrl_d            = wdata_i[7:0];
      ctrl_d[CB_RELOAD] = 1'b0;
      if (wdata_i[CB_RELOAD]) cnt_d = ival_q;
    end else if (ival_we_i) begin
      ival_d = wdata_i;
      cnt_d  = wdata_i;
    end else if (ctrl_q[CB_EN] && tick_i) begin
      if (cnt_q <= ONE) begin
        expire = 1'b1;
        if (ctrl_q[CB_ONCE]) begin
          cnt_d         = '0;
          ctrl_d[CB_EN] = 1'b0;
        end else begin
          cnt_d = ival_q;
        end
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      ival_q <= '0;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      ival_q <= ival_d;
      cnt_q  <= cnt_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign ival_o   = ival_q;
  assign cnt_o    = cnt_q;
  assign expire_o = expire;

  // R8
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && ctrl_q[CB_ONCE]) |=> (!ctrl_q[CB_EN] && cnt_q == '0));
  // R7
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !ctrl_q[CB_ONCE]) |=> (cnt_q == $past(ival_q)));
  // R6
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q[CB_EN] && !ctrl_we_i && !ival_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ivt_irq_ctrl.sv
module ivt_irq_ctrl #(
  parameter int NUM_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic              st_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [NUM_CH-1:0] expire_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] st_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] en_q, en_d;
  logic [NUM_CH-1:0] st_q, st_d;
  logic [NUM_CH-1:0] irq_q, irq_d;

  always_comb begin
    en_d  = en_we_i ? wdata_i : en_q;
    st_d  = (st_q & ~(st_we_i ? wdata_i : '0)) | expire_i;
    irq_d = expire_i & en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      st_q  <= '0;
      irq_q <= '0;
    end else begin
      en_q  <= en_d;
      st_q  <= st_d;
      irq_q <= irq_d;
    end
  end

  assign en_o  = en_q;
  assign st_o  = st_q;
  assign irq_o = irq_q;

  // R9
  irq_has_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q & ~st_q) == '0);
  // R11
  set_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i != '0) |=> ((st_q & $past(expire_i)) == $past(expire_i)));
endmodule

// File: rtl/ivt_array.sv
module ivt_array
  import ivt_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic              hi_zero;
  logic [7:0]        off;
  logic [3:0]        grp, sub;
  logic [NUM_CH-1:0] ch_sel, expire, ien, ist;
  logic [7:0]        ctrl   [NUM_CH];
  logic [CNT_W-1:0]  ival   [NUM_CH];
  logic [CNT_W-1:0]  cnt    [NUM_CH];
  logic [31:0]       wdc_q, wdc_d, wdm_q, wdm_d, rdata_q, rdata_d;
  logic              hit;

  assign hi_zero = (addr_i[ADDR_W-1:8] == '0);
  assign off     = addr_i[7:0];
  assign grp     = addr_i[7:4];
  assign sub     = addr_i[3:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_sel[i] = hi_zero && (grp == 4'(i + 1));
    ivt_channel #(.CNT_W(CNT_W)) chan_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .ctrl_we_i(wr_en_i && ch_sel[i] && sub == SUB_CTRL),
      .ival_we_i(wr_en_i && ch_sel[i] && sub == SUB_IVAL),
      .wdata_i  (wdata_i[CNT_W-1:0]),
      .ctrl_o   (ctrl[i]),
      .ival_o   (ival[i]),
      .cnt_o    (cnt[i]),
      .expire_o (expire[i])
    );
  end

  ivt_irq_ctrl #(.NUM_CH(NUM_CH)) irq_ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_we_i (wr_en_i && hi_zero && off == OFF_IEN),
    .st_we_i (wr_en_i && hi_zero && off == OFF_IST),
    .wdata_i (wdata_i[NUM_CH-1:0]),
    .expire_i(expire),
    .en_o    (ien),
    .st_o    (ist),
    .irq_o   (irq_o)
  );

  always_comb begin
    wdc_d = (wr_en_i && hi_zero && off == OFF_WDC) ? wdata_i : wdc_q;
    wdm_d = (wr_en_i && hi_zero && off == OFF_WDM) ? wdata_i : wdm_q;
  end

  always_comb begin
    rdata_d = '0;
    hit     = 1'b0;
    if (hi_zero) begin
      case (off)
        OFF_IEN: begin rdata_d[NUM_CH-1:0] = ien; hit = 1'b1; end
        OFF_IST: begin rdata_d[NUM_CH-1:0] = ist; hit = 1'b1; end
        OFF_WDC: begin rdata_d = wdc_q; hit = 1'b1; end
        OFF_WDM: begin rdata_d = wdm_q; hit = 1'b1; end
        default: ;
      endcase
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) begin
        case (sub)
          SUB_CTRL: begin rdata_d[7:0] = ctrl[i]; hit = 1'b1; end
          SUB_IVAL: begin rdata_d[CNT_W-1:0] = ival[i]; hit = 1'b1; end
          SUB_CNT:  begin rdata_d[CNT_W-1:0] = cnt[i]; hit = 1'b1; end
          default: ;
        endcase
      end
    end
    if (!rd_en_i) rdata_d = rdata_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdc_q   <= '0;
      wdm_q   <= '0;
      rdata_q <= '0;
    end else begin
      wdc_q   <= wdc_d;
      wdm_q   <= wdm_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  // R2
  undecoded_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit) |=> (rdata_o == '0));
  // R12
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/ivt_array_tb_top.sv
module ivt_array_tb_top;
  localparam int NUM_CH = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [9:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ivt_array dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wdata_i(wdata), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result against the queued expectation
  always @(posedge clk) begin
    if (rd_en) begin
      #1;
      if (exp_q.size() > 0) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({26'd0, irq}, 32'd0, "R1 irq idle");
    rd(10'h000, 32'h0, "R1 irq enable");
    rd(10'h004, 32'h0, "R1 irq status");
    rd(10'h010, 32'h04, "R1 ctrl ch0");
    rd(10'h060, 32'h04, "R1 ctrl ch5");
    rd(10'h014, 32'h0, "R1 interval ch0");
    rd(10'h018, 32'h0, "R1 count ch0");

    // R2 map, storage and undecoded offsets
    wr(10'h090, 32'hDEADBEEF);
    wr(10'h094, 32'h12345678);
    wr(10'h0F0, 32'h5);
    wr(10'h01C, 32'h7);
    rd(10'h090, 32'hDEADBEEF, "R2 wd ctrl");
    rd(10'h094, 32'h12345678, "R2 wd mode");
    rd(10'h0F0, 32'h0, "R2 undecoded");
    rd(10'h01C, 32'h0, "R2 channel hole");
    rd(10'h110, 32'h0, "R2 high address");

    // R4 interval loads count
    wr(10'h014, 32'd5);
    rd(10'h014, 32'd5, "R4 interval");
    rd(10'h018, 32'd5, "R4 count loaded");

    // R6 stopped channel holds, running counts
    ticks(3);
    rd(10'h018, 32'd5, "R6 stopped hold");
    wr(10'h010, 32'h01);
    ticks(2);
    rd(10'h018, 32'd3, "R6 decrement");
    rd(10'h010, 32'h01, "R5 ctrl readback");

    // R7 R9 expiry with interrupt disabled
    ticks(2);
    rd(10'h018, 32'd1, "R6 count at 1");
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk({26'd0, irq}, 32'd0, "R10 masked irq");
    rd(10'h004, 32'h01, "R9 status set while masked");
    rd(10'h018, 32'd5, "R7 periodic reload");
    wr(10'h004, 32'h3E);
    rd(10'h004, 32'h01, "R3 zero bits keep status");
    wr(10'h004, 32'h01);
    rd(10'h004, 32'h00, "R3 one bit clears status");

    // R10 pulse when enabled
    wr(10'h000, 32'h01);
    ticks(4);
    rd(10'h018, 32'd1, "R7 second period count");
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk({26'd0, irq}, 32'h01, "R10 pulse high");
    @(negedge clk);
    chk({26'd0, irq}, 32'h00, "R10 pulse single cycle");
    wr(10'h010, 32'h00);
    ticks(3);
    rd(10'h018, 32'd5, "R6 hold after stop");

    // R8 one-shot on ch2
    wr(10'h004, 32'h3F);
    wr(10'h000, 32'h05);
    wr(10'h034, 32'd3);
    wr(10'h030, 32'h81);
    ticks(3);
    rd(10'h030, 32'h80, "R8 enable cleared");
    rd(10'h038, 32'd0, "R8 count zero");
    rd(10'h004, 32'h04, "R9 one-shot status");
    wr(10'h004, 32'h04);
    ticks(2);
    rd(10'h038, 32'd0, "R8 stays stopped");
    rd(10'h004, 32'h00, "R8 no further expiry");

    // R5 reload bit, field storage, count write ignored
    wr(10'h030, 32'h02);
    rd(10'h038, 32'd3, "R5 reload copies interval");
    rd(10'h030, 32'h00, "R5 reload reads zero");
    wr(10'h030, 32'h0C);
    rd(10'h030, 32'h0C, "R5 clock select stored");
    wr(10'h038, 32'd99);
    rd(10'h038, 32'd3, "R5 count write ignored");

    // R11 write wins over tick
    wr(10'h024, 32'd10);
    wr(10'h020, 32'h01);
    @(negedge clk); tick = 1'b1; addr = 10'h024; wdata = 32'd7; wr_en = 1'b1;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(10'h028, 32'd7, "R11 write beats tick");
    ticks(1);
    rd(10'h028, 32'd6, "R11 still running");
    wr(10'h020, 32'h00);

    // R11 expiry set beats clear
    wr(10'h004, 32'h3F);
    wr(10'h044, 32'd1);
    wr(10'h040, 32'h01);
    @(negedge clk); tick = 1'b1; addr = 10'h004; wdata = 32'h08; wr_en = 1'b1;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(10'h004, 32'h08, "R11 set beats clear");
    wr(10'h040, 32'h00);
    wr(10'h004, 32'h3F);

    // R10 last channel pulse
    wr(10'h000, 32'h20);
    wr(10'h064, 32'd2);
    wr(10'h060, 32'h01);
    @(negedge clk); tick = 1'b1;
    @(negedge clk);
    @(negedge clk); tick = 1'b0;
    chk({26'd0, irq}, 32'h20, "R10 ch5 pulse");
    @(negedge clk);
    chk({26'd0, irq}, 32'h00, "R10 ch5 pulse ends");
    rd(10'h004, 32'h20, "R9 ch5 status");

    // R12 read data held
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    chk(rdata, 32'h20, "R12 rdata held");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule